// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one page-mode write session and then programs them into a byte-wide storage array in a single timed internal write cycle. A session begins when a start address is loaded. The upper address bits pick a page and the lower bits pick the first byte position inside it. Each byte-load strobe drops one byte into a 64-entry staging buffer and sets that entry's valid flag. The in-page position then moves forward. It wraps from the last byte of the page back to byte 0 of the same page, so a long burst overwrites what it loaded earlier.

A commit pulse starts the internal write cycle, provided at least one byte is valid. A busy flag stays high for a fixed, parameterised number of clock cycles, which models the multi-millisecond programming time of a nonvolatile cell. While busy is high, only the flagged bytes are copied into the selected page, and every other byte of that page keeps its old content. The valid flags are cleared when the cycle ends and whenever a new start address is loaded. A behavioural array sits behind the buffer and powers up erased. It offers a registered byte read port that is shut while a write cycle is in progress.

The full configuration uses 8 page-select bits, which gives 256 pages of 64 bytes (16K bytes, 14-bit address). The default parameter set uses 5 page-select bits so that the behavioural array stays small when it is elaborated on its own. The defaults are an 11-bit address, a 6-bit offset and 32 pages.

Top module: `pwb_top`

## Requirements
- R1: After reset, busy is 0, and every array byte reads back as 8'hFF.
- R2: An accepted session start copies start_addr[ADDR_W-1:OFF_W] into the page register and start_addr[OFF_W-1:0] into the offset register. It also clears all valid flags, so bytes loaded before it are never committed.
- R3: Each accepted byte load writes load_byte into the buffer entry selected by the current offset and marks that entry valid. The offset then increments, wrapping from 63 to 0, and the page bits do not change.
- R4: Loading a buffer entry that is already valid replaces its byte, and the commit programs the most recently loaded value.
- R5: A commit accepted while at least one entry is valid raises busy on the next clock edge. Busy then stays high for exactly WR_CYCLES consecutive cycles.
- R6: A commit programs exactly the valid entries into page-register*64+entry. Every other byte of that page, and all other pages, keep their contents.
- R7: A commit while no entry is valid leaves busy at 0 and changes no array byte.
- R8: While busy is 1, session starts, byte loads and commits are ignored.
- R9: While busy is 1, read requests are ignored, and rd_data holds its value.
- R10: A read request while busy is 0 presents the array byte at rd_addr on rd_data after the next clock edge.
- R11: The valid flags are cleared when a write cycle ends, so a second commit with no loads in between behaves as in R7.
- R12: In a cycle with commit high, any session start or byte load is ignored. A byte load that arrives together with a session start is also ignored, and the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_start | input | 1 | Load a new session start address |
| start_addr | input | ADDR_W | Session start address (page bits over offset bits) |
| load_en | input | 1 | Byte-load strobe |
| load_byte | input | 8 | Byte to stage |
| commit | input | 1 | Request the internal write cycle |
| busy | output | 1 | Internal write cycle in progress |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench aims at the offset wrap from 63 to 0 and at reloads of the same entry within a long burst. A design that got these wrong would spill bytes into the next page or program a stale byte. Commits with nothing staged, and second commits straight after a write cycle, would show a stuck or early busy if the valid flags failed to clear. Session starts, loads, commits and reads are all issued in the middle of a write cycle. A design that let any of them through would change the programmed page or rd_data. The bench also drives loads in the same cycle as a start or a commit, and it counts the busy cycles against the exact expected length.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int DEF_OFF_W  = 6;
    localparam int DEF_SEL_W  = 5;
    localparam int DEF_WR_CYC = 500000;

    typedef logic [7:0] byte_t;

    localparam byte_t ERASED_BYTE = 8'hFF;

    typedef enum logic [0:0] {
        CYC_IDLE = 1'b0,
        CYC_PROG = 1'b1
    } cyc_state_e;

    // Accepted front-end actions, evaluated against busy and same-cycle priorities.
    typedef struct packed {
        logic start_ok;
        logic load_ok;
        logic commit_ok;
        logic read_ok;
    } accept_t;

    function automatic accept_t decide(input logic busy, input logic start,
                                       input logic load, input logic commit,
                                       input logic read);
        accept_t a;
        a.commit_ok = commit && !busy;
        a.start_ok  = start && !busy && !commit;
        a.load_ok   = load && !busy && !commit && !start;
        a.read_ok   = read && !busy;
        return a;
    endfunction

endpackage

// File: rtl/pwb_buffer.sv
module pwb_buffer
    import pwb_pkg::*;
#(
    parameter int OFF_W = DEF_OFF_W,
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_ok,
    input  logic [SEL_W+OFF_W-1:0] start_addr,
    input  logic                   load_ok,
    input  byte_t                  load_byte,
    input  logic                   clr_valid,
    input  logic [OFF_W-1:0]       rd_slot,
    output logic [SEL_W-1:0]       page,
    output logic [OFF_W-1:0]       offset,
    output logic [(1<<OFF_W)-1:0]  valid,
    output byte_t                  slot_byte
);
    localparam int NSLOT = 1 << OFF_W;

    byte_t slot_data [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            page   <= '0;
            offset <= '0;
        end else if (start_ok) begin
            page   <= start_addr[SEL_W+OFF_W-1:OFF_W];
            offset <= start_addr[OFF_W-1:0];
        end else if (load_ok) begin
            offset <= offset + 1'b1;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit;
        assign hit = load_ok && (offset == OFF_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[s]     <= 1'b0;
                slot_data[s] <= ERASED_BYTE;
            end else begin
                if (start_ok || clr_valid) begin
                    valid[s] <= 1'b0;
                end else if (hit) begin
                    valid[s] <= 1'b1;
                end
                if (hit) begin
                    slot_data[s] <= load_byte;
                end
            end
        end
    end

    assign slot_byte = slot_data[rd_slot];

endmodule

// File: rtl/pwb_cycle_ctrl.sv
module pwb_cycle_ctrl
    import pwb_pkg::*;
#(
    parameter int OFF_W     = DEF_OFF_W,
    parameter int WR_CYCLES = DEF_WR_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_ok,
    input  logic             any_valid,
    output logic             busy,
    output logic             prog_phase,
    output logic [OFF_W-1:0] prog_slot,
    output logic             done
);
    localparam int NSLOT = 1 << OFF_W;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

    cyc_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CYC_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                CYC_IDLE: begin
                    cnt <= '0;
                    if (commit_ok && any_valid) begin
                        state <= CYC_PROG;
                    end
                end
                CYC_PROG: begin
                    if (cnt == LAST) begin
                        state <= CYC_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end

    assign busy       = (state == CYC_PROG);
    assign prog_phase = busy && (cnt < CNT_W'(NSLOT));
    assign prog_slot  = cnt[OFF_W-1:0];
    assign done       = busy && (cnt == LAST);

endmodule

// File: rtl/pwb_array.sv
module pwb_array
    import pwb_pkg::*;
#(
    parameter int ADDR_W = DEF_SEL_W + DEF_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= ERASED_BYTE;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= ERASED_BYTE;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int OFF_W     = DEF_OFF_W,
    parameter int SEL_W     = DEF_SEL_W,
    parameter int WR_CYCLES = DEF_WR_CYC,
    localparam int ADDR_W   = SEL_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sess_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              load_en,
    input  logic [7:0]        load_byte,
    input  logic              commit,
    output logic              busy,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int NSLOT = 1 << OFF_W;

    accept_t          acc;
    logic [SEL_W-1:0] page;
    logic [OFF_W-1:0] offset;
    logic [NSLOT-1:0] valid;
    byte_t            slot_byte;
    logic             prog_phase;
    logic [OFF_W-1:0] prog_slot;
    logic             done;
    logic             arr_we;

    assign acc = decide(busy, sess_start, load_en, commit, rd_req);

    pwb_buffer #(.OFF_W(OFF_W), .SEL_W(SEL_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .start_ok   (acc.start_ok),
        .start_addr (start_addr),
        .load_ok    (acc.load_ok),
        .load_byte  (load_byte),
        .clr_valid  (done),
        .rd_slot    (prog_slot),
        .page       (page),
        .offset     (offset),
        .valid      (valid),
        .slot_byte  (slot_byte)
    );

    pwb_cycle_ctrl #(.OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .commit_ok  (acc.commit_ok),
        .any_valid  (|valid),
        .busy       (busy),
        .prog_phase (prog_phase),
        .prog_slot  (prog_slot),
        .done       (done)
    );

    assign arr_we = prog_phase && valid[prog_slot];

    pwb_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr ({page, prog_slot}),
        .wdata (slot_byte),
        .re    (acc.read_ok),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int OFF_W     = 6,
    parameter int SEL_W     = 5,
    parameter int WR_CYCLES = 500000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  busy,
    input logic                  commit,
    input logic                  sess_start,
    input logic                  load_en,
    input logic [(1<<OFF_W)-1:0] valid,
    input logic [OFF_W-1:0]      offset,
    input logic [SEL_W-1:0]      page,
    input logic [7:0]            rd_data
);
    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else begin
            run <= busy ? run + 1 : '0;
        end
    end

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (commit && !busy && (valid != '0)) |=> busy); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == WR_CYCLES)); // R5

    AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (commit && !busy && (valid == '0)) |=> !busy); // R7

    AST_OFFSET_WRAP: assert property (@(posedge clk) disable iff (rst)
        (load_en && !busy && !commit && !sess_start)
        |=> (offset == $past(offset) + 1'b1) && $stable(page)); // R3

    AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (valid == '0)); // R11

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_data)); // R9

    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(page) && $stable(offset)); // R8

endmodule

bind pwb_top pwb_checker #(
    .OFF_W     (OFF_W),
    .SEL_W     (SEL_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .commit     (commit),
    .sess_start (sess_start),
    .load_en    (load_en),
    .valid      (valid),
    .offset     (offset),
    .page       (page),
    .rd_data    (rd_data)
);

// File: tb/sim_pwb_top.sv
module sim_pwb_top;

    localparam int OFF_W  = 6;
    localparam int SEL_W  = 5;
    localparam int WR     = 80;
    localparam int AW     = SEL_W + OFF_W;
    localparam int NSLOT  = 1 << OFF_W;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sess_start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          load_en = 1'b0;
    logic [7:0]    load_byte = '0;
    logic          commit = 1'b0;
    logic          busy;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0]       ref_mem [DEPTH];
    logic [7:0]       rbuf [NSLOT];
    logic [NSLOT-1:0] rvalid;
    logic [SEL_W-1:0] rpage;
    logic [OFF_W-1:0] roff;

    always #5 clk = ~clk;

    pwb_top #(.OFF_W(OFF_W), .SEL_W(SEL_W), .WR_CYCLES(WR)) u0 (
        .clk(clk), .rst(rst), .sess_start(sess_start), .start_addr(start_addr),
        .load_en(load_en), .load_byte(load_byte), .commit(commit), .busy(busy),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model of the requirements.
    task automatic m_start(input logic [AW-1:0] a);
        rpage  = a[AW-1:OFF_W];
        roff   = a[OFF_W-1:0];
        rvalid = '0;
    endtask

    task automatic m_load(input logic [7:0] d);
        rbuf[roff]   = d;
        rvalid[roff] = 1'b1;
        roff         = roff + 1'b1;
    endtask

    function automatic int exp_busy_len(input logic [NSLOT-1:0] v);
        return (v != '0) ? WR : 0;
    endfunction

    task automatic m_commit();
        for (int s = 0; s < NSLOT; s++) begin
            if (rvalid[s]) ref_mem[{rpage, OFF_W'(s)}] = rbuf[s];
        end
        rvalid = '0;
    endtask

    // Stimulus tasks: entered and left at a falling edge.
    task automatic do_start(input logic [AW-1:0] a);
        sess_start = 1'b1; start_addr = a;
        @(negedge clk);
        sess_start = 1'b0;
        m_start(a);
    endtask

    task automatic do_load(input logic [7:0] d);
        load_en = 1'b1; load_byte = d;
        @(negedge clk);
        load_en = 1'b0;
        m_load(d);
    endtask

    task automatic do_commit(input string tag);
        int n = 0;
        int e = exp_busy_len(rvalid);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == e, tag, n, e);
        m_commit();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_data == ref_mem[a], tag, int'(rd_data), int'(ref_mem[a]));
    endtask

    task automatic check_page(input logic [SEL_W-1:0] p, input string tag);
        for (int s = 0; s < NSLOT; s++) begin
            do_read({p, OFF_W'(s)}, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        rvalid = '0; rpage = '0; roff = '0;
        for (int s = 0; s < NSLOT; s++) rbuf[s] = 8'h00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        do_read(AW'(0), "R1 erased low");
        do_read(AW'(DEPTH - 1), "R1 erased high");
        do_read(AW'(777), "R1 erased mid");

        // R7: commit with nothing staged
        do_commit("R7 empty commit busy length");
        check_page(SEL_W'(0), "R7 page untouched");

        // R3, R6: wrap from 63 to 0 within the page
        do_start({SEL_W'(3), OFF_W'(62)});
        do_load(8'hA1); do_load(8'hA2); do_load(8'hA3); do_load(8'hA4);
        do_commit("R5 busy length wrap session");
        check_page(SEL_W'(3), "R3 wrap page content");
        do_read({SEL_W'(4), OFF_W'(0)}, "R6 next page untouched");

        // R11: second commit with no loads
        do_commit("R11 commit after clear");

        // R4: reload the same entry through a full lap
        do_start({SEL_W'(7), OFF_W'(10)});
        for (int k = 0; k < NSLOT + 3; k++) do_load(8'(k + 8'h30));
        do_commit("R5 busy length overwrite session");
        check_page(SEL_W'(7), "R4 overwrite content");

        // R2: start clears earlier staged bytes
        do_start({SEL_W'(9), OFF_W'(0)});
        do_load(8'h55); do_load(8'h66);
        do_start({SEL_W'(9), OFF_W'(20)});
        do_load(8'h77);
        do_commit("R2 busy length");
        check_page(SEL_W'(9), "R2 only new session written");

        // R12: load together with start is ignored; start wins
        sess_start = 1'b1; start_addr = {SEL_W'(11), OFF_W'(5)};
        load_en = 1'b1; load_byte = 8'hEE;
        @(negedge clk);
        sess_start = 1'b0; load_en = 1'b0;
        m_start({SEL_W'(11), OFF_W'(5)});
        do_load(8'h12);
        do_commit("R12 busy length");
        check_page(SEL_W'(11), "R12 start beats load");

        // R12: load together with commit is ignored
        do_start({SEL_W'(12), OFF_W'(0)});
        do_load(8'h21);
        commit = 1'b1; load_en = 1'b1; load_byte = 8'h99;
        @(negedge clk);
        commit = 1'b0; load_en = 1'b0;
        begin
            int n = 1;
            while (busy && n < 1000) begin n++; @(negedge clk); end
            chk(n - 1 == WR, "R12 commit with load busy length", n - 1, WR);
        end
        m_commit();
        do_commit("R12 load during commit not staged");
        check_page(SEL_W'(12), "R12 commit beats load");

        // R8, R9, R10: requests during a write cycle
        do_read({SEL_W'(3), OFF_W'(62)}, "R10 read before cycle");
        held = rd_data;
        do_start({SEL_W'(14), OFF_W'(0)});
        do_load(8'hC3);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        m_commit();
        chk(busy == 1'b1, "R5 busy after commit", int'(busy), 1);
        rd_req = 1'b1; rd_addr = {SEL_W'(7), OFF_W'(20)};
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_data == held, "R9 read ignored while busy", int'(rd_data), int'(held));
        sess_start = 1'b1; start_addr = {SEL_W'(15), OFF_W'(0)};
        @(negedge clk);
        sess_start = 1'b0;
        load_en = 1'b1; load_byte = 8'hBB;
        @(negedge clk);
        load_en = 1'b0;
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        while (busy) @(negedge clk);
        do_commit("R8 nothing staged during busy");
        check_page(SEL_W'(15), "R8 page 15 untouched");
        check_page(SEL_W'(14), "R8 page 14 committed");

        // Random sessions
        for (int t = 0; t < 14; t++) begin
            logic [AW-1:0] a = AW'($urandom);
            int nl = 1 + int'($urandom % 90);
            do_start(a);
            for (int k = 0; k < nl; k++) do_load(8'($urandom));
            do_commit("R5 random busy length");
            check_page(a[AW-1:OFF_W], "R6 random page content");
            do_read(AW'($urandom), "R10 random read");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule